// File: doc/BRIEF.md
# Clock Slow-Mode and Ratio Controller

This block selects the source and the division ratios of a chip's core, bus and peripheral clocks. It also sequences power-down and relock of two PLLs: a main PLL and a USB PLL. Software programs two small registers through a plain write/read port. The first register chooses between the main PLL and a slow clock divided down from the oscillator. It also holds the power-down requests for both PLLs. The second register halves the bus clock relative to the core clock, and the peripheral clock relative to the bus clock.

All clocks are represented as per-cycle enables on the single reference clock `clk_i`. When the core runs from the main PLL, its enable is high on every reference cycle. Each PLL is reduced to a power-down output and a lock counter that reports stability. Every source or ratio change stops all derived enables for at least one cycle, at their low phase, before the new pattern starts. This keeps the downstream clock gates free of glitches.

Top module: `clkm_ctrl`

## Requirements
- R1: After reset, the slow register (address 0) reads 0x04 and the ratio register (address 1) reads 0x00.
- R2: Slow register fields are USB-off at bit 7, main-off at bit 5, slow at bit 4 and divider value at bits [2:0]. Ratio register fields are bus-halve at bit 1 and periph-halve at bit 0. All other bits read 0 and ignore writes.
- R3: With the slow bit at 0, `core_en_o` stays low until `mpll_stable_o` is high, then is high on every cycle.
- R4: In slow mode, `core_en_o` pulses once every 2×value reference cycles. A value of 0 gives a pulse every cycle.
- R5: With bus-halve set, `bus_en_o` pulses on every second core pulse; otherwise on every core pulse.
- R6: With periph-halve set, `per_en_o` pulses on every second bus pulse; otherwise on every bus pulse.
- R7: `mpll_pd_o` is high only while both the main-off bit and the slow bit are 1 and slow mode is in effect.
- R8: Clearing the slow bit is held pending. The core keeps its slow pattern until the main PLL has been powered for MPLL_LOCK_CYC cycles.
- R9: Any change of source or ratio produces at least one cycle with `core_en_o` low before the new pattern begins.
- R10: Setting USB-off raises `upll_pd_o` and drops `usb_en_o` on the next cycle. Clearing it keeps `usb_en_o` low for UPLL_LOCK_CYC cycles, then raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference (oscillator) clock |
| arst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 slow, 1 ratio |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of selected register |
| mpll_pd_o | output | 1 | Main PLL power-down |
| mpll_stable_o | output | 1 | Main PLL lock reached |
| upll_pd_o | output | 1 | USB PLL power-down |
| upll_stable_o | output | 1 | USB PLL lock reached |
| usb_en_o | output | 1 | USB clock enable |
| core_en_o | output | 1 | Core clock enable |
| bus_en_o | output | 1 | Bus clock enable |
| per_en_o | output | 1 | Peripheral clock enable |

## Verification
A write lands in the register on its own edge, so `rdata_o` and `upll_pd_o` are checked one cycle later. `mpll_pd_o` adds the slow-mode register and is checked two cycles after the write. A ratio change restarts the enable counters one cycle after the write, and the registered enables follow one cycle after that. For this reason, the rate checks wait ten cycles and then count pulses over 672 cycles. That window is a whole multiple of every period under test, so the count does not depend on phase. The lock waits are checked at points well inside and well past the configured counts. This avoids depending on single-cycle alignment.

// File: rtl/clkm_pkg.sv
package clkm_pkg;
  localparam int SVAL_W = 3;

  typedef struct packed {
    logic              slow;
    logic [SVAL_W-1:0] sval;
    logic              hdiv;
    logic              pdiv;
  } clk_cfg_t;

  localparam int B_UOFF = 7;
  localparam int B_MOFF = 5;
  localparam int B_SLOW = 4;
endpackage

// File: rtl/clkm_rst_sync.sv
module clkm_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/clkm_lock_cnt.sv
module clkm_lock_cnt #(
  parameter int LOCK_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic stable_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LOCK_V = CW'(LOCK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (pd_i)                cnt_d = '0;
    else if (cnt_q == LOCK_V) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign stable_o = (cnt_q == LOCK_V);

  // R10
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !stable_o);
endmodule

// File: rtl/clkm_en_gen.sv
module clkm_en_gen
  import clkm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     restart_i,
  input  clk_cfg_t cfg_i,
  output logic     core_en_o,
  output logic     bus_en_o,
  output logic     per_en_o
);
  localparam int PW = SVAL_W + 1;

  logic [PW-1:0] per_len, cnt_q, cnt_d;
  logic          bph_q, bph_d, pph_q, pph_d;
  logic          core_tick, bus_tick, per_tick;
  logic          core_q, bus_q, per_q;

  always_comb begin
    per_len = (cfg_i.slow && cfg_i.sval != '0) ? {cfg_i.sval, 1'b0} : PW'(1);
    core_tick = run_i && !restart_i && (cnt_q == '0);
    bus_tick  = core_tick && (!cfg_i.hdiv || !bph_q);
    per_tick  = bus_tick && (!cfg_i.pdiv || !pph_q);
    if (restart_i || !run_i)            cnt_d = '0;
    else if (cnt_q == per_len - 1'b1)   cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
    bph_d = restart_i ? 1'b0 : (core_tick ? !bph_q : bph_q);
    pph_d = restart_i ? 1'b0 : (bus_tick ? !pph_q : pph_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bph_q  <= 1'b0;
      pph_q  <= 1'b0;
      core_q <= 1'b0;
      bus_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bph_q  <= bph_d;
      pph_q  <= pph_d;
      core_q <= core_tick;
      bus_q  <= bus_tick;
      per_q  <= per_tick;
    end
  end

  assign core_en_o = core_q;
  assign bus_en_o  = bus_q;
  assign per_en_o  = per_q;

  // R9
  gap_on_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !core_en_o);
  // R5
  bus_in_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> core_en_o);
  // R6
  per_in_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |-> bus_en_o);
endmodule

// File: rtl/clkm_ctrl.sv
module clkm_ctrl
  import clkm_pkg::*;
#(
  parameter int MPLL_LOCK_CYC = 20,
  parameter int UPLL_LOCK_CYC = 12
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       mpll_pd_o,
  output logic       mpll_stable_o,
  output logic       upll_pd_o,
  output logic       upll_stable_o,
  output logic       usb_en_o,
  output logic       core_en_o,
  output logic       bus_en_o,
  output logic       per_en_o
);
  logic rst_n;
  logic uoff_q, moff_q, slow_q, hdiv_q, pdiv_q, slow_eff_q;
  logic uoff_d, moff_d, slow_d, hdiv_d, pdiv_d, slow_eff_d;
  logic [SVAL_W-1:0] sval_q, sval_d;
  clk_cfg_t cfg_now, cfg_q;
  logic restart, run;

  clkm_rst_sync u_rst (.clk_i(clk_i), .arst_ni(arst_ni), .rst_no(rst_n));

  always_comb begin
    uoff_d = uoff_q; moff_d = moff_q; slow_d = slow_q; sval_d = sval_q;
    hdiv_d = hdiv_q; pdiv_d = pdiv_q;
    if (wr_en_i && !addr_i) begin
      uoff_d = wdata_i[B_UOFF];
      moff_d = wdata_i[B_MOFF];
      slow_d = wdata_i[B_SLOW];
      sval_d = wdata_i[SVAL_W-1:0];
    end
    if (wr_en_i && addr_i) begin
      hdiv_d = wdata_i[1];
      pdiv_d = wdata_i[0];
    end
    // entering slow is immediate; leaving waits for main PLL lock
    if (slow_q)                         slow_eff_d = 1'b1;
    else if (slow_eff_q && mpll_stable_o) slow_eff_d = 1'b0;
    else                                slow_eff_d = slow_eff_q;
    cfg_now = '{slow: slow_eff_q, sval: sval_q, hdiv: hdiv_q, pdiv: pdiv_q};
    restart = (cfg_now != cfg_q);
    run     = slow_eff_q || mpll_stable_o;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      uoff_q <= 1'b0; moff_q <= 1'b0; slow_q <= 1'b0;
      sval_q <= SVAL_W'(4);
      hdiv_q <= 1'b0; pdiv_q <= 1'b0; slow_eff_q <= 1'b0;
      cfg_q  <= '{slow: 1'b0, sval: SVAL_W'(4), hdiv: 1'b0, pdiv: 1'b0};
    end else begin
      uoff_q <= uoff_d; moff_q <= moff_d; slow_q <= slow_d; sval_q <= sval_d;
      hdiv_q <= hdiv_d; pdiv_q <= pdiv_d; slow_eff_q <= slow_eff_d;
      cfg_q  <= cfg_now;
    end
  end

  always_comb begin
    if (!addr_i) rdata_o = {uoff_q, 1'b0, moff_q, slow_q, 1'b0, sval_q};
    else         rdata_o = {6'b0, hdiv_q, pdiv_q};
  end

  assign mpll_pd_o = moff_q && slow_q && slow_eff_q;
  assign upll_pd_o = uoff_q;
  assign usb_en_o  = upll_stable_o && !upll_pd_o;

  clkm_lock_cnt #(.LOCK_CYC(MPLL_LOCK_CYC)) u_mlock (
    .clk_i(clk_i), .rst_ni(rst_n), .pd_i(mpll_pd_o), .stable_o(mpll_stable_o));

  clkm_lock_cnt #(.LOCK_CYC(UPLL_LOCK_CYC)) u_ulock (
    .clk_i(clk_i), .rst_ni(rst_n), .pd_i(upll_pd_o), .stable_o(upll_stable_o));

  clkm_en_gen u_gen (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .restart_i(restart),
    .cfg_i(cfg_now), .core_en_o(core_en_o), .bus_en_o(bus_en_o),
    .per_en_o(per_en_o));

  // R7
  mpll_off_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    mpll_pd_o |-> slow_eff_q);
  // R8
  hold_until_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!slow_eff_q && !mpll_stable_o) |=> !core_en_o);
  // R10
  usb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    upll_pd_o |=> !usb_en_o);
endmodule

// File: tb/clkm_ctrl_tb_top.sv
module clkm_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       wr_en;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic mpll_pd, mpll_stable, upll_pd, upll_stable, usb_en;
  logic core_en, bus_en, per_en;

  int errors = 0;
  int checks = 0;
  localparam int W = 672;

  // slow, sval, hdiv, pdiv, core count, bus count, periph count over W cycles
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 3'd4, 1'b0, 1'b0, 10'd672, 10'd672, 10'd672},
    {1'b0, 3'd4, 1'b1, 1'b1, 10'd672, 10'd336, 10'd168},
    {1'b1, 3'd0, 1'b0, 1'b1, 10'd672, 10'd672, 10'd336},
    {1'b1, 3'd1, 1'b0, 1'b0, 10'd336, 10'd336, 10'd336},
    {1'b1, 3'd2, 1'b1, 1'b0, 10'd168, 10'd84,  10'd84},
    {1'b1, 3'd3, 1'b1, 1'b1, 10'd112, 10'd56,  10'd28},
    {1'b1, 3'd7, 1'b0, 1'b1, 10'd48,  10'd48,  10'd24},
    {1'b1, 3'd4, 1'b1, 1'b1, 10'd84,  10'd42,  10'd21}
  };

  clkm_ctrl #(.MPLL_LOCK_CYC(20), .UPLL_LOCK_CYC(12)) dut_i (
    .clk_i(clk), .arst_ni(arst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mpll_pd_o(mpll_pd),
    .mpll_stable_o(mpll_stable), .upll_pd_o(upll_pd),
    .upll_stable_o(upll_stable), .usb_en_o(usb_en), .core_en_o(core_en),
    .bus_en_o(bus_en), .per_en_o(per_en));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic count(input int n, output int c, output int b, output int p);
    c = 0; b = 0; p = 0;
    repeat (n) begin
      @(negedge clk);
      c += int'(core_en); b += int'(bus_en); p += int'(per_en);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int v, c, b, p;
    bit gap;
    arst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    rd(1'b0, v); chk("R1 slow reg", v, 8'h04);
    rd(1'b1, v); chk("R1 ratio reg", v, 8'h00);
    // R3 core held until main PLL lock
    chk("R3 core before lock", int'(core_en), 0);
    chk("R10 usb before lock", int'(usb_en), 0);
    repeat (30) @(negedge clk);
    chk("R3 core after lock", int'(core_en), 1);
    chk("R10 usb after lock", int'(usb_en), 1);
    // R2 reserved bits
    wr(1'b1, 8'hFF); rd(1'b1, v); chk("R2 ratio reserved", v, 8'h03);
    wr(1'b0, 8'h4F); rd(1'b0, v); chk("R2 slow reserved", v, 8'h47 & 8'hB7);
    wr(1'b1, 8'h00); wr(1'b0, 8'h04);
    repeat (30) @(negedge clk);
    // R7 off request ignored while not slow
    wr(1'b0, 8'h24); @(negedge clk);
    chk("R7 pd without slow", int'(mpll_pd), 0);
    wr(1'b0, 8'h04);
    repeat (5) @(negedge clk);
    // R4 R5 R6 table
    foreach (VEC[i]) begin
      wr(1'b1, {6'b0, VEC[i][31], VEC[i][30]});
      wr(1'b0, {3'b000, VEC[i][35], 1'b0, VEC[i][34:32]});
      repeat (10) @(negedge clk);
      count(W, c, b, p);
      chk("R4 core rate", c, int'(VEC[i][29:20]));
      chk("R5 bus rate", b, int'(VEC[i][19:10]));
      chk("R6 periph rate", p, int'(VEC[i][9:0]));
    end
    // R7 power-down in slow mode
    wr(1'b0, 8'h34); @(negedge clk);
    chk("R7 pd in slow", int'(mpll_pd), 1);
    @(negedge clk);
    chk("R7 lock lost", int'(mpll_stable), 0);
    // R8 pending exit from slow mode
    wr(1'b0, 8'h04);
    count(16, c, b, p);
    chk("R8 still slow", c, 2);
    repeat (30) @(negedge clk);
    count(16, c, b, p);
    chk("R8 main after lock", c, 16);
    // R9 gap on ratio change
    wr(1'b1, 8'h00);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h02);
    gap = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (!core_en) gap = 1'b1;
    end
    chk("R9 gap seen", int'(gap), 1);
    // R10 USB PLL off and relock
    wr(1'b0, 8'h84);
    chk("R10 upll pd", int'(upll_pd), 1);
    chk("R10 usb off", int'(usb_en), 0);
    wr(1'b0, 8'h04);
    repeat (4) @(negedge clk);
    chk("R10 usb waits", int'(usb_en), 0);
    repeat (15) @(negedge clk);
    chk("R10 usb back", int'(usb_en), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule